// File: doc/BRIEF.md
# Programmable-Rate Voice Playback Channel

This block is one playback channel for stored voice data. Software writes a rate divisor, a section start address, a section end address and a control word. From then on the channel reads one 10-bit word per sample period from an external sample memory. It walks the address from the start to the end of the section and presents each word with a one-cycle valid strobe. The sample period is a number of system clocks. With a 2 MHz system clock, the allowed divisor range of 100 to 800 gives sample rates between 20 kHz and 2.5 kHz.

A reloadable down-counter sets the sample period. The period therefore stays exact from one sample to the next, and a new divisor never shortens a period that is already running. When the last word of a section has been played, the channel either stops and raises an end flag, or, with its repeat bit set, goes back to the start address. The restart leaves no gap, so a looped sound plays continuously with no processor action.

Top module: `voice_rate_channel`

## Requirements
- R1: After reset, busy, the end flag and the sample strobe are all low, and the memory address is zero.
- R2: A divisor write below 100 acts as 100, and a divisor write above 800 acts as 800. A value inside that range is used unchanged.
- R3: While busy, the sample strobe pulses once every D system clocks, where D is the divisor in force. The first pulse comes D clocks after the control write that starts playback.
- R4: Each strobe carries the memory word that was at the presented address during the cycle before the strobe. Successive strobes cover the addresses start, start+1, ... up to and including end.
- R5: When the end-address sample is strobed with repeat clear, busy falls and the end flag rises in that same cycle. The memory address then stays at the end address, and no further strobes follow.
- R6: With repeat set, the strobe after the end-address sample carries the word at the start address, one normal period later. Playback goes on indefinitely.
- R7: A divisor written while a period is running does not change that period. The new value governs the periods that follow it.
- R8: Register select codes: 0 is the divisor, 1 is the start address, 2 is the end address and 3 is control. In the control word, bit 0 is go and bit 1 is repeat. A control write with go=0 stops playback, clears busy and does not raise the end flag.
- R9: A control write with go=1 clears the end flag, sets busy and restarts the section from the start address.
- R10: The sample strobe is never high for two consecutive cycles and never appears while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 divisor, 1 start, 2 end, 3 control) |
| wrData | input | ADDR_W | Register write value |
| memAddr | output | ADDR_W | Address presented to the sample memory |
| memData | input | 10 | Word returned by the sample memory for memAddr |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| sampleData | output | 10 | Captured sample word |
| busy | output | 1 | Channel is playing |
| endFlag | output | 1 | Section finished without repeat |

## Verification
A wrong rate count shows within one sample period as a gap between strobes that differs from the divisor. A mis-stepped or badly reloaded address shows at the very next strobe as a data word that does not match the expected address. A wrong decision at the end of the section shows within one period after the last sample: the end flag rises when it should not, busy stays high, or the strobe after the end address carries the wrong word. The bench therefore measures every strobe gap in cycles and compares every captured word with a computed memory pattern.

// File: rtl/voice_chan_pkg.sv
package voice_chan_pkg;

  localparam logic [1:0] SEL_DIV   = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_END   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  localparam int CTRL_GO_BIT     = 0;
  localparam int CTRL_REPEAT_BIT = 1;

  typedef struct packed {
    logic run;        // rate counter counts down
    logic restart;    // counter reloads, playback begins
    logic loadStart;  // address returns to the section start
    logic step;       // address advances by one
    logic capture;    // sample word is latched
  } chanStrobes_t;

endpackage

// File: rtl/voice_chan_datapath.sv
module voice_chan_datapath
  import voice_chan_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 10,
  parameter int DIV_MIN = 100,
  parameter int DIV_MAX = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [DATA_W-1:0] memData,
  input  chanStrobes_t      strb,
  output logic              tick,
  output logic              atEnd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] sampleData
);

  localparam int DIV_W = $clog2(DIV_MAX + 1);

  logic [DIV_W-1:0]  divReg;
  logic [DIV_W-1:0]  cnt;
  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] endReg;
  logic [DIV_W-1:0]  divClamped;

  // Clamp the requested divisor into the legal window at write time
  always_comb begin
    if (wrData < ADDR_W'(DIV_MIN))      divClamped = DIV_W'(DIV_MIN);
    else if (wrData > ADDR_W'(DIV_MAX)) divClamped = DIV_W'(DIV_MAX);
    else                                divClamped = wrData[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divReg   <= DIV_W'(DIV_MIN);
      startReg <= '0;
      endReg   <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_DIV:   divReg   <= divClamped;
        SEL_START: startReg <= wrData;
        SEL_END:   endReg   <= wrData;
        default:   ;
      endcase
    end
  end

  // Rate counter: reloads from divReg only at terminal count or restart
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (strb.restart)     cnt <= divReg - DIV_W'(1);
    else if (strb.run) begin
      if (cnt == '0)           cnt <= divReg - DIV_W'(1);
      else                     cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick  = strb.run && (cnt == '0);
  assign atEnd = (addr == endReg);

  always_ff @(posedge clk) begin
    if (!rst_n)              addr <= '0;
    else if (strb.loadStart) addr <= startReg;
    else if (strb.step)      addr <= addr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            sampleData <= '0;
    else if (strb.capture) sampleData <= memData;
  end

  // Counter never holds more than the largest legal period allows (R2, R3)
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DIV_W'(DIV_MAX - 1));

  // A step strobe moves the address forward by exactly one (R4)
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.loadStart) |=> addr == $past(addr) + ADDR_W'(1));

endmodule

// File: rtl/voice_chan_control.sv
module voice_chan_control
  import voice_chan_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic         goBit,
  input  logic         repeatBit,
  input  logic         tick,
  input  logic         atEnd,
  output chanStrobes_t strb,
  output logic         busy,
  output logic         endFlag,
  output logic         sampleValid
);

  logic ctrlWr;
  logic repeatReg;
  logic lastSample;

  assign ctrlWr     = wrEn && (wrSel == SEL_CTRL);
  assign lastSample = tick && atEnd;

  always_comb begin
    strb.run       = busy;
    strb.restart   = ctrlWr && goBit;
    strb.loadStart = strb.restart || (lastSample && repeatReg);
    strb.step      = tick && !atEnd;
    strb.capture   = tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      repeatReg   <= 1'b0;
      busy        <= 1'b0;
      endFlag     <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= tick;
      if (ctrlWr) begin
        repeatReg <= repeatBit;
        busy      <= goBit;
        endFlag   <= 1'b0;
      end else if (lastSample && !repeatReg) begin
        busy    <= 1'b0;
        endFlag <= 1'b1;
      end
    end
  end

  // A strobe only follows a cycle in which the channel was playing (R10)
  assert_valid_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> $past(busy));

  // Strobe is a single-cycle pulse (R10)
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  // Finished and playing are mutually exclusive (R5)
  assert_end_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && endFlag));

  // End flag rises together with the final strobe (R5)
  assert_end_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(endFlag) |-> sampleValid);

endmodule

// File: rtl/voice_rate_channel.sv
module voice_rate_channel
  import voice_chan_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 10,
  parameter int DIV_MIN = 100,
  parameter int DIV_MAX = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              busy,
  output logic              endFlag
);

  chanStrobes_t strb;
  logic tick;
  logic atEnd;

  voice_chan_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .goBit       (wrData[CTRL_GO_BIT]),
    .repeatBit   (wrData[CTRL_REPEAT_BIT]),
    .tick        (tick),
    .atEnd       (atEnd),
    .strb        (strb),
    .busy        (busy),
    .endFlag     (endFlag),
    .sampleValid (sampleValid)
  );

  voice_chan_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .memData    (memData),
    .strb       (strb),
    .tick       (tick),
    .atEnd      (atEnd),
    .addr       (memAddr),
    .sampleData (sampleData)
  );

endmodule

// File: tb/voice_rate_channel_tb.sv
module voice_rate_channel_tb;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrSel = 2'd0;
  logic [ADDR_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              sampleValid;
  logic [DATA_W-1:0] sampleData;
  logic              busy;
  logic              endFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return DATA_W'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic int expClamp(input int v);
    if (v < 100) return 100;
    if (v > 800) return 800;
    return v;
  endfunction

  assign memData = memWord(memAddr);

  voice_rate_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .memAddr(memAddr), .memData(memData), .sampleValid(sampleValid),
    .sampleData(sampleData), .busy(busy), .endFlag(endFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = ADDR_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Counts negedges until the strobe is seen; returns the gap in cycles
  task automatic waitSample(output int gap);
    gap = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      gap++;
      if (sampleValid) return;
    end
    gap = -1;
  endtask

  // Plays one section and checks every gap, word, and the end behaviour
  task automatic playSection(input int divRaw, input int st, input int len,
                             input bit rep, input int loops);
    int d, gap, a, n;
    d = expClamp(divRaw);
    writeReg(2'd0, divRaw);
    writeReg(2'd1, st);
    writeReg(2'd2, st + len - 1);
    writeReg(2'd3, rep ? 3 : 1);
    check(busy && !endFlag, "R9", "busy after go", int'(busy), 1);
    n = rep ? len * loops : len;
    for (int k = 0; k < n; k++) begin
      a = st + (k % len);
      waitSample(gap);
      check(gap == d, "R3", "strobe gap", gap, d);
      check(sampleData == memWord(ADDR_W'(a)), "R4", "sample word",
            int'(sampleData), int'(memWord(ADDR_W'(a))));
      if (rep && (k % len) == len - 1 && k != n - 1)
        check(busy && !endFlag, "R6", "still busy at wrap", int'(busy), 1);
    end
    if (!rep) begin
      check(!busy && endFlag, "R5", "busy/end at last sample",
            int'({busy, endFlag}), 1);
      for (int i = 0; i < d + 5; i++) begin
        @(negedge clk);
        if (sampleValid) check(1'b0, "R5", "strobe after end", 1, 0);
      end
      check(memAddr == ADDR_W'(st + len - 1), "R5", "address holds end",
            int'(memAddr), st + len - 1);
    end else begin
      writeReg(2'd3, 0);
      check(!busy && !endFlag, "R8", "stop write", int'({busy, endFlag}), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap, seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !endFlag && !sampleValid && memAddr == '0, "R1", "reset state",
          int'({busy, endFlag, sampleValid}), 0);

    // R3/R4/R5: directed basic section
    playSection(150, 40, 3, 1'b0, 1);
    // R2: clamps at both limits and an exact edge value
    playSection(5, 100, 2, 1'b0, 1);
    playSection(1000, 7, 1, 1'b0, 1);
    playSection(800, 9, 1, 1'b0, 1);
    // R6: repeat loops three times
    playSection(120, 200, 3, 1'b1, 3);
    // R6: single-word section in repeat
    playSection(100, 55, 1, 1'b1, 4);

    // R7: divisor change mid-period
    writeReg(2'd0, 300);
    writeReg(2'd1, 10);
    writeReg(2'd2, 20);
    writeReg(2'd3, 1);
    repeat (50) @(negedge clk);
    writeReg(2'd0, 120);
    waitSample(gap);
    check(gap == 300 - 52, "R7", "running period kept", gap, 248);
    waitSample(gap);
    check(gap == 120, "R7", "new period used", gap, 120);

    // R8: stop mid-section, no end flag, no strobes afterwards
    writeReg(2'd3, 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sampleValid) seen++;
    end
    check(!busy && !endFlag, "R8", "stop clears busy only", int'({busy, endFlag}), 0);
    check(seen == 0, "R10", "no strobe while idle", seen, 0);

    // R9: restart after an end clears the flag
    playSection(100, 3, 1, 1'b0, 1);
    writeReg(2'd3, 1);
    check(!endFlag && busy, "R9", "go clears end flag", int'(endFlag), 0);
    writeReg(2'd3, 0);

    // Random sections
    for (int t = 0; t < 10; t++) begin
      int dv, st, ln;
      bit rp;
      dv = int'($urandom_range(0, 1023));
      st = int'($urandom_range(0, 1000000));
      ln = int'($urandom_range(1, 4));
      rp = 1'($urandom_range(0, 1));
      playSection(dv, st, ln, rp, 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule